// File: doc/BRIEF.md
# Field-Based Shutter and Exposure Sequencer

This block sets the field-by-field shutter timing for an image sensor timing generator. The surrounding timing core supplies a field-start strobe, a line-start strobe, a marker for the line that carries the charge-transfer (VSG) pulse, and the running pixel counter. From these inputs the block drives the substrate-clear pulse output (SUBCK). In normal operation each line can carry up to two SUBCK pulses. Each pulse is placed by a pair of programmable pixel positions, and the number of pulses in one field is capped.

Software arms a sequence by writing trigger bits. At the next field start the block turns those bits into level outputs for the mechanical shutter, flash strobe and substrate-voltage control. It can also run an exposure of N fields, during which both SUBCK and the transfer-gate enable are held back. A readout can follow, either on its own or chained automatically after the exposure. In a readout, the field that carries the transfer pulse runs normally and SUBCK stays quiet for a programmed number of fields after it. A separate count drops a number of SUBCK pulses that follow the transfer line. An optional gate silences the vertical and horizontal sync outputs during exposures longer than one field.

Top module: `shutter_seq`

## Requirements
- R1: After reset, `subck_o` equals `subck_pol_i` (idle level), `vsg_en_o` and `vdhd_en_o` are 1, and `vsub_o`, `mshut_o`, `strobe_o` are 0.
- R2: With no sequence running, each toggle pair p (start at `tog_i[p*24 +: 12]`, stop at `tog_i[p*24+12 +: 12]`) drives `subck_o` to the inverse of `subck_pol_i` starting the cycle after `pix_i` equals the start value. The output returns to idle the cycle after `pix_i` equals the stop value, so the pulse is active for stop minus start cycles.
- R3: A start or stop position of all ones (4095) never fires. A pulse without a stop ends at the next line or field start.
- R4: At most `pulse_num_i` SUBCK pulses occur per field. Pulses are counted in pixel order across lines, and the count restarts at each field start.
- R5: When `vsg_line_i` comes with `line_start_i` while transfers are enabled, the next `pulse_skip_i` pulses are dropped. Dropped pulses still count toward the per-field limit.
- R6: Trigger encoding: bit 0 substrate voltage, bit 1 mechanical shutter, bit 2 strobe, bit 3 exposure, bit 4 readout. Pending bits are taken at the next field start. Bits 0 to 2 then appear on `vsub_o`, `mshut_o` and `strobe_o` for the whole sequence, or for one field if no exposure or readout runs.
- R7: An exposure trigger with `exp_fields_i` = N > 0 gives N fields with no SUBCK pulse and `vsg_en_o` = 0.
- R8: `vdhd_en_o` is 0 during an exposure only when `vdhd_off_i` is 1 and N > 1.
- R9: A readout runs one field with transfers and normal SUBCK. SUBCK is then held off for `rd_fields_i` further fields, after which the block returns to normal.
- R10: When the exposure and readout bits are set together, the readout starts automatically at the field start that ends the exposure.
- R11: Trigger bits clear once taken, so a sequence runs once per write and can be armed again.
- R12: Trigger writes made while a sequence runs are discarded.
- R13: Exposure and readout counters change only at field starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| field_start_i | input | 1 | One-cycle field start strobe |
| line_start_i | input | 1 | One-cycle line start strobe |
| vsg_line_i | input | 1 | Marks the transfer line; valid with line_start_i |
| pix_i | input | 12 | Pixel counter within the line |
| trig_wr_i | input | 1 | Trigger write strobe |
| trig_i | input | 5 | Trigger bits (see R6) |
| exp_fields_i | input | 12 | Exposure length in fields |
| rd_fields_i | input | 3 | Fields of SUBCK hold-off after readout |
| vdhd_off_i | input | 1 | Gate sync outputs during long exposure |
| pulse_num_i | input | 12 | SUBCK pulses allowed per field |
| pulse_skip_i | input | 12 | SUBCK pulses dropped after transfer line |
| subck_pol_i | input | 1 | SUBCK idle level |
| tog_i | input | 48 | Start/stop positions for two pulses |
| subck_o | output | 1 | Substrate clear pulse |
| vsg_en_o | output | 1 | Transfer gate enable |
| vdhd_en_o | output | 1 | Sync output enable |
| vsub_o | output | 1 | Substrate voltage control level |
| mshut_o | output | 1 | Mechanical shutter level |
| strobe_o | output | 1 | Flash strobe level |

## Verification
The hardest state to reach is a chained exposure and readout. It needs a trigger written in one field, N quiet fields, a readout field, and then a run of hold-off fields, all observed through pulse counts that only show up across whole fields. The bench drives complete fields of three lines through one task and records the pulse count and the output levels of each field. It also writes a rejected trigger partway through an exposure. It then runs enough fields afterwards to show that the rejected trigger never turns into a readout.

// File: rtl/shseq_pkg.sv
package shseq_pkg;
   localparam int NTRIG     = 5;
   localparam int TB_VSUB   = 0;
   localparam int TB_MSHUT  = 1;
   localparam int TB_STROBE = 2;
   localparam int TB_EXPO   = 3;
   localparam int TB_READ   = 4;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EXPO = 2'd1,
      ST_READ = 2'd2
   } seq_st_e;
endpackage

// File: rtl/shseq_tog_match.sv
module shseq_tog_match #(
   parameter int PW = 12
) (
   input  logic [PW-1:0] pix_i,
   input  logic [PW-1:0] start_i,
   input  logic [PW-1:0] stop_i,
   output logic          start_hit_o,
   output logic          stop_hit_o
);
   localparam logic [PW-1:0] NEVER = {PW{1'b1}};

   always_comb begin
      start_hit_o = (start_i != NEVER) && (pix_i == start_i);
      stop_hit_o  = (stop_i  != NEVER) && (pix_i == stop_i);
   end
endmodule

// File: rtl/shseq_fsm.sv
module shseq_fsm
   import shseq_pkg::*;
#(
   parameter int FW = 12,
   parameter int RW = 3
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            field_start_i,
   input  logic            trig_wr_i,
   input  logic [NTRIG-1:0] trig_i,
   input  logic [FW-1:0]   exp_fields_i,
   input  logic [RW-1:0]   rd_fields_i,
   input  logic            vdhd_off_i,
   output seq_st_e         state_o,
   output logic            fsupp_o,
   output logic            vsg_en_o,
   output logic            vdhd_en_o,
   output logic [2:0]      lvl_o
);
   seq_st_e          state_q;
   logic [NTRIG-1:0] pend_q;
   logic [FW-1:0]    ecnt_q;
   logic [RW-1:0]    rcnt_q;
   logic             rfirst_q;
   logic             auto_q;
   logic             long_q;
   logic [2:0]       lvl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         pend_q   <= '0;
         ecnt_q   <= '0;
         rcnt_q   <= '0;
         rfirst_q <= 1'b0;
         auto_q   <= 1'b0;
         long_q   <= 1'b0;
         lvl_q    <= '0;
      end else if (field_start_i) begin
         unique case (state_q)
            ST_IDLE: begin
               pend_q <= '0;
               lvl_q  <= pend_q[TB_STROBE:TB_VSUB];
               if (pend_q[TB_EXPO] && (exp_fields_i != '0)) begin
                  state_q <= ST_EXPO;
                  ecnt_q  <= exp_fields_i;
                  auto_q  <= pend_q[TB_READ];
                  long_q  <= (exp_fields_i > FW'(1));
               end else if (pend_q[TB_READ]) begin
                  state_q  <= ST_READ;
                  rcnt_q   <= rd_fields_i;
                  rfirst_q <= 1'b1;
               end
            end
            ST_EXPO: begin
               if (ecnt_q == FW'(1)) begin
                  if (auto_q) begin
                     state_q  <= ST_READ;
                     rcnt_q   <= rd_fields_i;
                     rfirst_q <= 1'b1;
                  end else begin
                     state_q <= ST_IDLE;
                     lvl_q   <= '0;
                  end
               end else begin
                  ecnt_q <= ecnt_q - FW'(1);
               end
            end
            ST_READ: begin
               if (rcnt_q == '0) begin
                  state_q <= ST_IDLE;
                  lvl_q   <= '0;
               end else begin
                  rcnt_q   <= rcnt_q - RW'(1);
                  rfirst_q <= 1'b0;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end else if (trig_wr_i && (state_q == ST_IDLE)) begin
         pend_q <= pend_q | trig_i;
      end
   end

   always_comb begin
      state_o   = state_q;
      fsupp_o   = (state_q == ST_EXPO) || ((state_q == ST_READ) && !rfirst_q);
      vsg_en_o  = (state_q != ST_EXPO);
      vdhd_en_o = !(vdhd_off_i && (state_q == ST_EXPO) && long_q);
      lvl_o     = lvl_q;
   end

   // R12
   busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE) |=> $stable(pend_q));

   // R13
   expo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_EXPO && !field_start_i) |=> (state_q == ST_EXPO && $stable(ecnt_q)));

   // R8
   vdhd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vdhd_en_o |-> (state_q == ST_EXPO && vdhd_off_i));
endmodule

// File: rtl/shseq_subck.sv
module shseq_subck #(
   parameter int PW    = 12,
   parameter int CW    = 12,
   parameter int NPAIR = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  field_start_i,
   input  logic                  line_start_i,
   input  logic                  vsg_line_i,
   input  logic                  vsg_en_i,
   input  logic                  fsupp_i,
   input  logic [PW-1:0]         pix_i,
   input  logic [CW-1:0]         num_i,
   input  logic [CW-1:0]         skip_i,
   input  logic [NPAIR*2*PW-1:0] tog_i,
   output logic                  act_o
);
   logic [NPAIR-1:0] start_hit;
   logic [NPAIR-1:0] stop_hit;
   logic [CW-1:0]    pcnt_q;
   logic [CW-1:0]    sleft_q;
   logic             act_q;
   logic             start_any;
   logic             stop_any;

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      shseq_tog_match #(.PW(PW)) match_i (
         .pix_i      (pix_i),
         .start_i    (tog_i[p*2*PW +: PW]),
         .stop_i     (tog_i[p*2*PW+PW +: PW]),
         .start_hit_o(start_hit[p]),
         .stop_hit_o (stop_hit[p])
      );
   end

   always_comb begin
      start_any = |start_hit;
      stop_any  = |stop_hit;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q   <= 1'b0;
         pcnt_q  <= '0;
         sleft_q <= '0;
      end else if (field_start_i) begin
         act_q   <= 1'b0;
         pcnt_q  <= '0;
         sleft_q <= '0;
      end else if (line_start_i) begin
         act_q <= 1'b0;
         if (vsg_line_i && vsg_en_i) sleft_q <= skip_i;
      end else if (start_any && !fsupp_i && (pcnt_q < num_i)) begin
         pcnt_q <= pcnt_q + CW'(1);
         if (sleft_q != '0) sleft_q <= sleft_q - CW'(1);
         else               act_q   <= 1'b1;
      end else if (stop_any) begin
         act_q <= 1'b0;
      end
   end

   assign act_o = act_q;

   // R7
   quiet_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(act_q) |-> $past(!fsupp_i));

   // R4
   pulse_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(act_q) |-> ($past(pcnt_q) < $past(num_i)));

   // R5
   skip_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(sleft_q) != '0 && !$past(field_start_i) && !$past(line_start_i)) |-> !$rose(act_q));
endmodule

// File: rtl/shutter_seq.sv
module shutter_seq
   import shseq_pkg::*;
#(
   parameter int PW    = 12,
   parameter int FW    = 12,
   parameter int RW    = 3,
   parameter int CW    = 12,
   parameter int NPAIR = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  field_start_i,
   input  logic                  line_start_i,
   input  logic                  vsg_line_i,
   input  logic [PW-1:0]         pix_i,
   input  logic                  trig_wr_i,
   input  logic [NTRIG-1:0]      trig_i,
   input  logic [FW-1:0]         exp_fields_i,
   input  logic [RW-1:0]         rd_fields_i,
   input  logic                  vdhd_off_i,
   input  logic [CW-1:0]         pulse_num_i,
   input  logic [CW-1:0]         pulse_skip_i,
   input  logic                  subck_pol_i,
   input  logic [NPAIR*2*PW-1:0] tog_i,
   output logic                  subck_o,
   output logic                  vsg_en_o,
   output logic                  vdhd_en_o,
   output logic                  vsub_o,
   output logic                  mshut_o,
   output logic                  strobe_o
);
   if (PW < 2)                 begin : g_bad_pw    $error("PW must be at least 2"); end
   if (FW < 1 || RW < 1)       begin : g_bad_cnt   $error("field counters need width"); end
   if (NPAIR < 1 || NPAIR > 4) begin : g_bad_npair $error("NPAIR must be 1..4"); end

   seq_st_e    state;
   logic       fsupp;
   logic       act;
   logic [2:0] lvl;

   shseq_fsm #(.FW(FW), .RW(RW)) fsm_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .field_start_i(field_start_i),
      .trig_wr_i    (trig_wr_i),
      .trig_i       (trig_i),
      .exp_fields_i (exp_fields_i),
      .rd_fields_i  (rd_fields_i),
      .vdhd_off_i   (vdhd_off_i),
      .state_o      (state),
      .fsupp_o      (fsupp),
      .vsg_en_o     (vsg_en_o),
      .vdhd_en_o    (vdhd_en_o),
      .lvl_o        (lvl)
   );

   shseq_subck #(.PW(PW), .CW(CW), .NPAIR(NPAIR)) subck_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .field_start_i(field_start_i),
      .line_start_i (line_start_i),
      .vsg_line_i   (vsg_line_i),
      .vsg_en_i     (vsg_en_o),
      .fsupp_i      (fsupp),
      .pix_i        (pix_i),
      .num_i        (pulse_num_i),
      .skip_i       (pulse_skip_i),
      .tog_i        (tog_i),
      .act_o        (act)
   );

   always_comb begin
      subck_o  = act ? !subck_pol_i : subck_pol_i;
      vsub_o   = lvl[TB_VSUB];
      mshut_o  = lvl[TB_MSHUT];
      strobe_o = lvl[TB_STROBE];
   end

   // R7
   expo_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == ST_EXPO) |-> (subck_o == subck_pol_i && !vsg_en_o));
endmodule

// File: tb/shutter_seq_tb.sv
`timescale 1ns/1ps
module shutter_seq_tb_top;
   localparam int LLEN  = 40;
   localparam int NLINE = 3;
   localparam logic [11:0] NV = 12'hFFF;

   typedef struct packed {
      logic        pol;
      logic [11:0] s0, e0, s1, e1, num;
      logic [15:0] xpulses, xactive;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{1'b1, 12'd5, 12'd9,  NV,     NV,     12'd10, 16'd3, 16'd12},
      '{1'b1, 12'd5, 12'd9,  12'd20, 12'd23, 12'd10, 16'd6, 16'd21},
      '{1'b1, 12'd5, 12'd9,  12'd20, 12'd23, 12'd4,  16'd4, 16'd14},
      '{1'b1, 12'd5, 12'd9,  12'd20, 12'd23, 12'd0,  16'd0, 16'd0},
      '{1'b1, NV,    12'd9,  12'd20, 12'd23, 12'd10, 16'd3, 16'd9},
      '{1'b1, 12'd5, NV,     NV,     NV,     12'd2,  16'd2, 16'd70},
      '{1'b0, 12'd5, 12'd9,  12'd20, 12'd23, 12'd10, 16'd6, 16'd21}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        field_start = 1'b0, line_start = 1'b0, vsg_line = 1'b0;
   logic [11:0] pix = NV;
   logic        trig_wr = 1'b0;
   logic [4:0]  trig = '0;
   logic [11:0] exp_fields = '0;
   logic [2:0]  rd_fields = '0;
   logic        vdhd_off = 1'b0;
   logic [11:0] pnum = 12'd10, pskip = '0;
   logic        pol = 1'b1;
   logic [47:0] tog = '1;
   logic        subck, vsg_en, vdhd_en, vsub, mshut, strobe;

   int checks = 0, fails = 0;
   int f_pulses, f_active;
   logic f_vsg, f_vdhd, f_vsub, f_mshut, f_strobe, prev_act;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   shutter_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .field_start_i(field_start), .line_start_i(line_start),
      .vsg_line_i(vsg_line), .pix_i(pix), .trig_wr_i(trig_wr), .trig_i(trig),
      .exp_fields_i(exp_fields), .rd_fields_i(rd_fields), .vdhd_off_i(vdhd_off),
      .pulse_num_i(pnum), .pulse_skip_i(pskip), .subck_pol_i(pol), .tog_i(tog),
      .subck_o(subck), .vsg_en_o(vsg_en), .vdhd_en_o(vdhd_en), .vsub_o(vsub),
      .mshut_o(mshut), .strobe_o(strobe)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      logic a;
      @(posedge clk);
      #1;
      a = (subck != pol);
      if (a) f_active++;
      if (a && !prev_act) f_pulses++;
      prev_act = a;
      f_vsg = vsg_en; f_vdhd = vdhd_en; f_vsub = vsub; f_mshut = mshut; f_strobe = strobe;
   endtask

   task automatic run_field(input int vln);
      f_pulses = 0; f_active = 0; prev_act = 1'b0;
      field_start = 1'b1; pix = NV;
      cyc();
      field_start = 1'b0;
      for (int ln = 0; ln < NLINE; ln++) begin
         line_start = 1'b1; vsg_line = (ln == vln); pix = NV;
         cyc();
         line_start = 1'b0; vsg_line = 1'b0;
         for (int p = 0; p < LLEN; p++) begin
            pix = 12'(p);
            cyc();
         end
      end
      pix = NV;
      cyc();
   endtask

   task automatic wr_trig(input logic [4:0] b);
      trig_wr = 1'b1; trig = b;
      cyc();
      trig_wr = 1'b0; trig = '0;
   endtask

   task automatic std_cfg();
      pol = 1'b1; pnum = 12'd10; pskip = '0;
      tog = {12'd23, 12'd20, 12'd9, 12'd5};
   endtask

   initial begin
      #500000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 subck idle", subck, pol);
      check("R1 vsg_en", vsg_en, 1);
      check("R1 vdhd_en", vdhd_en, 1);
      check("R1 levels", {vsub, mshut, strobe}, 0);

      // Vector table: pass-through pulses (R2 R3 R4)
      foreach (VECS[i]) begin
         pol = VECS[i].pol; pnum = VECS[i].num; pskip = '0;
         tog = {VECS[i].e1, VECS[i].s1, VECS[i].e0, VECS[i].s0};
         run_field(-1);
         check($sformatf("R2 R3 R4 row %0d pulses", i), f_pulses, int'(VECS[i].xpulses));
         check($sformatf("R2 R3 row %0d active", i), f_active, int'(VECS[i].xactive));
      end

      // R5 skip after transfer line
      std_cfg(); pskip = 12'd2;
      run_field(1);
      check("R5 pulses after skip", f_pulses, 4);
      check("R5 active after skip", f_active, 14);
      pskip = '0;

      // R6 R7 R8 R12 R13 exposure of 3 fields
      exp_fields = 12'd3; rd_fields = 3'd1; vdhd_off = 1'b1;
      wr_trig(5'b01111);
      for (int f = 0; f < 3; f++) begin
         run_field(1);
         check("R7 R13 expo pulses", f_pulses, 0);
         check("R7 expo vsg_en", f_vsg, 0);
         check("R8 long expo vdhd_en", f_vdhd, 0);
         check("R6 levels in expo", {f_vsub, f_mshut, f_strobe}, 3'b111);
         if (f == 1) wr_trig(5'b10000);
      end
      run_field(1);
      check("R7 R13 expo ended pulses", f_pulses, 6);
      check("R7 vsg_en back", f_vsg, 1);
      check("R6 levels cleared", {f_vsub, f_mshut, f_strobe}, 0);
      run_field(1);
      run_field(1);
      check("R12 busy write discarded", f_pulses, 6);

      // R8 single-field exposure keeps sync outputs
      exp_fields = 12'd1;
      wr_trig(5'b01000);
      run_field(1);
      check("R8 short expo vdhd_en", f_vdhd, 1);
      check("R7 short expo vsg_en", f_vsg, 0);
      run_field(1);
      check("R7 short expo ends", f_pulses, 6);

      // R10 R9 chained readout
      exp_fields = 12'd2; rd_fields = 3'd2; vdhd_off = 1'b0;
      wr_trig(5'b11000);
      for (int f = 0; f < 2; f++) begin
         run_field(1);
         check("R10 expo part pulses", f_pulses, 0);
      end
      run_field(1);
      check("R10 readout field vsg_en", f_vsg, 1);
      check("R9 readout field pulses", f_pulses, 6);
      for (int f = 0; f < 2; f++) begin
         run_field(1);
         check("R9 holdoff pulses", f_pulses, 0);
         check("R9 holdoff vsg_en", f_vsg, 1);
      end
      run_field(1);
      check("R9 after holdoff", f_pulses, 6);

      // R9 readout alone
      rd_fields = 3'd1;
      wr_trig(5'b10000);
      run_field(1);
      check("R9 solo readout field", f_pulses, 6);
      run_field(1);
      check("R9 solo holdoff", f_pulses, 0);
      run_field(1);
      check("R9 solo after", f_pulses, 6);

      // R11 self-clearing trigger, re-armed
      wr_trig(5'b00010);
      run_field(1);
      check("R11 shutter first", f_mshut, 1);
      run_field(1);
      check("R11 shutter cleared", f_mshut, 0);
      wr_trig(5'b00010);
      run_field(1);
      check("R11 shutter rearmed", f_mshut, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule